// File: doc/BRIEF.md
# Fixed Set-Point Bistable with Pretrip Delay

This block watches one sampled process value and raises two protection flags against a fixed threshold. Once per scan, marked by a one-cycle enable strobe, the value is compared with the set-point. The comparison is integer and two's-complement by default. A direction select chooses between a high trip (value at or above the set-point) and a low trip (value below the set-point). The trip flag shows the result of the most recent scan.

The pretrip warning flag rises only after the trip condition has held over a run of consecutive scans. A small saturating persistence timer counts that run. A delay input sets how many earlier consecutive tripping scans must precede the scan that raises the warning. The timer has six states, so the usable delay is 0 to 5. The delay is captured only while the timer is idle, so a change during a count cannot cut the count short. The registered warning is fed back into the next scan's evaluation, so once raised it holds until a scan finds the condition gone. Both flags update only on strobed scans and hold between them.

The reset input is asynchronous and active low. It is released into the clock domain through a two-stage synchronizer.

Top module: `bst_bistable`

## Requirements
- R1: With dir_fall = 0, a strobed scan sets trip_o at that clock edge exactly when proc_val >= setpoint, compared as signed two's-complement numbers.
- R2: With dir_fall = 1, a strobed scan sets trip_o exactly when proc_val < setpoint, compared as signed numbers (for example, -6 against -5 trips and -5 against -5 does not).
- R3: On a strobed scan where the condition holds, pretrip_o rises when at least D earlier consecutive strobed scans also held it, where D is the effective delay. With D = 0 it rises together with trip_o on the first tripping scan.
- R4: A strobed scan where the condition is false clears trip_o and pretrip_o at that edge and restarts the persistence count from zero.
- R5: The persistence timer saturates at 5 and does not wrap. While the condition stays true on every strobed scan, pretrip_o stays high however long the run lasts.
- R6: delay_cfg values 6 and 7 act as a delay of 5, so pretrip_o rises on the sixth consecutive tripping scan.
- R7: delay_cfg is taken only while the persistence timer is zero. A change made while a count is running has no effect until the count returns to zero.
- R8: On cycles with scan_en = 0, trip_o, pretrip_o and the persistence count hold their values whatever proc_val, setpoint, dir_fall and delay_cfg do.
- R9: While arst_n is low, trip_o and pretrip_o are 0 and the timer is cleared.
- R10: pretrip_o is never 1 while trip_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scan_en | input | 1 | Scan strobe; state advances only when high |
| proc_val | input | W (12) | Sampled process value |
| setpoint | input | W (12) | Fixed trip threshold |
| dir_fall | input | 1 | 0 = trip at or above set-point, 1 = trip below set-point |
| delay_cfg | input | DLY_W (3) | Pretrip persistence delay in scans, clamped to 5 |
| trip_o | output | 1 | Trip flag from the latest strobed scan |
| pretrip_o | output | 1 | Persistence-qualified warning flag |

## Verification
The hardest situation to reach is a delay change that lands while a count is in progress. It takes a long enough run of tripping scans with the strobe present, followed by a new delay value before the run ends. A random mix rarely produces this and then a long-enough continuation. Directed sequences therefore start a run under one delay, switch to a shorter delay in mid-run, and check that the warning still waits for the captured length. A second sequence does the same with idle strobe cycles inserted in the run. The constrained random phase keeps the value within a few counts of the set-point, so runs of varied length break and restart under both directions while the delay occasionally changes.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic {
    DIR_RISE = 1'b0,
    DIR_FALL = 1'b1
  } trip_dir_e;
endpackage

// File: rtl/bst_rst_sync.sv
module bst_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/bst_compare.sv
module bst_compare
  import bst_pkg::*;
#(
  parameter int W          = 12,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] limit_i,
  input  trip_dir_e    dir_i,
  output logic         cond_o
);
  logic at_or_above;

  generate
    if (SIGNED_CMP) begin : g_signed
      assign at_or_above = ($signed(value_i) >= $signed(limit_i));
    end else begin : g_unsigned
      assign at_or_above = (value_i >= limit_i);
    end
  endgenerate

  // Low trip is the strict complement of the high trip test
  always_comb begin
    if (dir_i == DIR_FALL) cond_o = !at_or_above;
    else                   cond_o = at_or_above;
  end
endmodule

// File: rtl/bst_persist_timer.sv
module bst_persist_timer #(
  parameter int TIMER_STATES = 6,
  parameter int DLY_W        = 3,
  localparam int CNT_W       = $clog2(TIMER_STATES),
  localparam int TMAX        = TIMER_STATES - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             cond_i,
  input  logic [DLY_W-1:0] delay_cfg_i,
  output logic [CNT_W-1:0] count_o,
  output logic             delay_met_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] delay_q, delay_d;
  logic [CNT_W-1:0] delay_clamped;
  logic [CNT_W-1:0] delay_eff;
  logic             idle;

  assign idle = (count_q == '0);

  always_comb begin
    if (delay_cfg_i > DLY_W'(TMAX)) delay_clamped = CNT_W'(TMAX);
    else                            delay_clamped = CNT_W'(delay_cfg_i);
  end

  // Live setting while idle, captured setting while counting
  assign delay_eff   = idle ? delay_clamped : delay_q;
  assign delay_met_o = (count_q >= delay_eff);

  always_comb begin
    delay_d = delay_q;
    if (idle) delay_d = delay_clamped;
  end

  always_comb begin
    count_d = count_q;
    if (scan_en) begin
      if (!cond_i)                       count_d = '0;
      else if (count_q != CNT_W'(TMAX))  count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      delay_q <= '0;
    end else begin
      count_q <= count_d;
      delay_q <= delay_d;
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/bst_flag_reg.sv
module bst_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic cond_i,
  input  logic delay_met_i,
  output logic trip_o,
  output logic pretrip_o
);
  logic trip_q, trip_d;
  logic pre_q,  pre_d;

  // Previous warning is fed back: once raised it latches until the condition drops
  always_comb begin
    trip_d = trip_q;
    pre_d  = pre_q;
    if (scan_en) begin
      trip_d = cond_i;
      pre_d  = cond_i && (pre_q || delay_met_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      pre_q  <= 1'b0;
    end else begin
      trip_q <= trip_d;
      pre_q  <= pre_d;
    end
  end

  assign trip_o    = trip_q;
  assign pretrip_o = pre_q;
endmodule

// File: rtl/bst_bistable.sv
module bst_bistable
  import bst_pkg::*;
#(
  parameter int W            = 12,
  parameter bit SIGNED_CMP   = 1'b1,
  parameter int TIMER_STATES = 6,
  parameter int DLY_W        = 3
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             scan_en,
  input  logic [W-1:0]     proc_val,
  input  logic [W-1:0]     setpoint,
  input  logic             dir_fall,
  input  logic [DLY_W-1:0] delay_cfg,
  output logic             trip_o,
  output logic             pretrip_o
);
  localparam int CNT_W = $clog2(TIMER_STATES);
  localparam int TMAX  = TIMER_STATES - 1;

  logic             rst_sync_n;
  logic             cond_w;
  logic             delay_met_w;
  logic [CNT_W-1:0] timer_w;
  trip_dir_e        dir_w;

  assign dir_w = trip_dir_e'(dir_fall);

  bst_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_sync_n)
  );

  bst_compare #(.W(W), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
    .value_i (proc_val),
    .limit_i (setpoint),
    .dir_i   (dir_w),
    .cond_o  (cond_w)
  );

  bst_persist_timer #(.TIMER_STATES(TIMER_STATES), .DLY_W(DLY_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .scan_en     (scan_en),
    .cond_i      (cond_w),
    .delay_cfg_i (delay_cfg),
    .count_o     (timer_w),
    .delay_met_o (delay_met_w)
  );

  bst_flag_reg u_flags (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .scan_en     (scan_en),
    .cond_i      (cond_w),
    .delay_met_i (delay_met_w),
    .trip_o      (trip_o),
    .pretrip_o   (pretrip_o)
  );
endmodule

// File: rtl/bst_bistable_chk.sv
module bst_bistable_chk #(
  parameter int CNT_W = 3,
  parameter int TMAX  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_en,
  input logic             cond,
  input logic [CNT_W-1:0] timer,
  input logic             trip,
  input logic             pretrip
);
  AST_TRIP_FOLLOWS_COND: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (trip == $past(cond)));                                   // R1

  AST_CLEAR_ON_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !cond) |=> (!trip && !pretrip && (timer == '0)));          // R4

  AST_TIMER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && cond && (timer == CNT_W'(TMAX))) |=> (timer == CNT_W'(TMAX))); // R5

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> ($stable(trip) && $stable(pretrip) && $stable(timer)));   // R8

  AST_PRETRIP_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    pretrip |-> trip);                                                     // R10

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (!trip && !pretrip && (timer == '0)));                      // R9
endmodule

bind bst_bistable bst_bistable_chk #(.CNT_W(CNT_W), .TMAX(TMAX)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .scan_en (scan_en),
  .cond    (cond_w),
  .timer   (timer_w),
  .trip    (trip_o),
  .pretrip (pretrip_o)
);

// File: tb/bst_bistable_tb_top.sv
`timescale 1ns/1ps
module bst_bistable_tb_top;
  localparam int W = 12;

  logic                clk;
  logic                arst_n;
  logic                scan_en;
  logic signed [W-1:0] proc_val;
  logic signed [W-1:0] setpoint;
  logic                dir_fall;
  logic [2:0]          delay_cfg;
  logic                trip_o;
  logic                pretrip_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench model state
  int m_tm;
  int m_dh;
  bit m_pre;
  bit m_trip;

  bst_bistable dut_i (
    .clk       (clk),
    .arst_n    (arst_n),
    .scan_en   (scan_en),
    .proc_val  (proc_val),
    .setpoint  (setpoint),
    .dir_fall  (dir_fall),
    .delay_cfg (delay_cfg),
    .trip_o    (trip_o),
    .pretrip_o (pretrip_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit model_cond(input logic signed [W-1:0] v,
                                    input logic signed [W-1:0] sp,
                                    input logic dir);
    if (dir) return (v < sp);
    return (v >= sp);
  endfunction

  function automatic int clamp_dly(input logic [2:0] d);
    return (int'(d) > 5) ? 5 : int'(d);
  endfunction

  task automatic check_bit(input string tag, input string what,
                           input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_tm = 0; m_dh = 0; m_pre = 0; m_trip = 0;
  endtask

  // Drive one cycle at the falling edge, advance the model, check after the rising edge
  task automatic step(input logic en, input int v, input int sp, input logic dir,
                      input logic [2:0] d, input string tag);
    bit c;
    int dl;
    @(negedge clk);
    scan_en   = en;
    proc_val  = W'(v);
    setpoint  = W'(sp);
    dir_fall  = dir;
    delay_cfg = d;
    c  = model_cond(W'(v), W'(sp), dir);
    dl = (m_tm == 0) ? clamp_dly(d) : m_dh;
    m_dh = dl;
    if (en) begin
      if (c) begin
        m_pre  = m_pre || (m_tm >= dl);
        m_trip = 1'b1;
        m_tm   = (m_tm < 5) ? m_tm + 1 : 5;
      end else begin
        m_pre = 0; m_trip = 0; m_tm = 0;
      end
    end
    @(posedge clk);
    #1;
    check_bit(tag, "trip_o", trip_o, m_trip);
    check_bit(tag, "pretrip_o", pretrip_o, m_pre);
  endtask

  task automatic do_reset();
    @(negedge clk);
    arst_n = 1'b0;
    scan_en = 1'b0;
    #1;
    model_reset();
    check_bit("R9", "trip_o in reset", trip_o, 1'b0);
    check_bit("R9", "pretrip_o in reset", pretrip_o, 1'b0);
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    int sp_r;
    logic dir_r;
    logic [2:0] d_r;
    seed = $urandom(32'd20417);
    arst_n = 1'b0; scan_en = 1'b0; proc_val = '0; setpoint = '0;
    dir_fall = 1'b0; delay_cfg = 3'd0;
    model_reset();
    repeat (3) @(negedge clk);
    check_bit("R9", "trip_o after power-up reset", trip_o, 1'b0);
    check_bit("R9", "pretrip_o after power-up reset", pretrip_o, 1'b0);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: rising boundary, equal trips, one below does not
    step(1, 99, 100, 0, 3'd0, "R1");
    step(1, 100, 100, 0, 3'd0, "R1");   // delay 0: pretrip with trip (R3)
    step(1, -1, 100, 0, 3'd0, "R4");
    step(1, -50, -60, 0, 3'd0, "R1");   // signed: -50 >= -60

    // R2: falling, signed values
    step(1, -5, -5, 1, 3'd0, "R2");
    step(1, -6, -5, 1, 3'd0, "R2");
    step(1, 2047, -5, 1, 3'd0, "R2");

    // R3: delay 3 -> pretrip on fourth consecutive scan
    for (int i = 0; i < 5; i++) step(1, 200, 150, 0, 3'd3, "R3");
    step(1, 100, 150, 0, 3'd3, "R4");

    // R6: delay 7 clamps to 5 -> sixth scan
    for (int i = 0; i < 7; i++) step(1, 10, 10, 0, 3'd7, "R6");
    step(1, 9, 10, 0, 3'd7, "R4");
    for (int i = 0; i < 6; i++) step(1, 10, 10, 0, 3'd6, "R6");

    // R5: long run keeps pretrip, timer saturates
    for (int i = 0; i < 20; i++) step(1, 10, 10, 0, 3'd6, "R5");
    step(1, 0, 10, 0, 3'd0, "R4");

    // R7: start with delay 4, switch to 0 mid-count
    step(1, 30, 20, 0, 3'd4, "R7");
    for (int i = 0; i < 5; i++) step(1, 30, 20, 0, 3'd0, "R7");
    step(1, 0, 20, 0, 3'd0, "R4");

    // R7 + R8: idle cycles within a run, inputs wandering
    step(1, 30, 20, 0, 3'd2, "R7");
    step(0, 0, 20, 1, 3'd0, "R8");
    step(0, -900, 700, 0, 3'd0, "R8");
    step(1, 30, 20, 0, 3'd0, "R7");
    step(0, 0, 20, 0, 3'd0, "R8");
    step(1, 30, 20, 0, 3'd0, "R7");
    step(0, -2000, 20, 0, 3'd5, "R8");
    step(1, 0, 20, 0, 3'd0, "R4");

    // R9: reset in the middle of a tripped run
    for (int i = 0; i < 3; i++) step(1, 5, 0, 0, 3'd0, "R3");
    do_reset();
    step(0, 5, 0, 0, 3'd0, "R9");

    // Constrained random
    sp_r = 0; dir_r = 0; d_r = 3'd2;
    for (int n = 0; n < 4000; n++) begin
      int off;
      logic en_r;
      if (n % 40 == 0) begin
        sp_r  = $urandom_range(0, 400) - 200;
        dir_r = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 9) == 0) d_r = 3'($urandom_range(0, 7));
      en_r = ($urandom_range(0, 9) != 0);
      off  = $urandom_range(0, 9) - 3;
      if (dir_r) off = -off;
      step(en_r, sp_r + off, sp_r, dir_r, d_r, dir_r ? "R2/R3" : "R1/R3");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule